// File: doc/BRIEF.md
# Bus and Pin Wake-Up Detector

This block watches for wake-up requests while a bus transceiver sits in one of its low-power modes. It has two sources. The first is a local wake pin: a change of its level in either direction counts once the new level has held for a filter time. The second is the bus: a remote request is a dominant phase, a recessive phase and a second dominant phase, each at least a minimum length, and all three inside one overall time window. Every time is a count of pulses on a tick-enable input, so the real-time values (a local filter of about 25 µs, a phase minimum of about 1.75 µs and a window of 0.5 to 2 ms) come from the tick rate and the count parameters.

The block holds a wake flag and a wake-source flag. The wake-source flag marks a wake that came from the local pin. When a request is accepted it also gives a single-cycle wake event. The mode controller arms detection while the transceiver is in a low-power mode. It also drives the clearing inputs: entering normal mode, leaving normal mode, and the core-supply undervoltage flag. Both flags are set out of reset, as they are at power-on.

Top module: `wake_detector`

## Requirements
- R1: While reset is applied and on the first cycle after it, `wake_flag` = 1, `wake_src` = 1 and `wake_evt` = 0.
- R2: Once `wake_pin` differs from the stored reference level for LOCAL_T consecutive ticks, a local request is accepted on the clock edge of the LOCAL_T-th tick. This holds for rising and falling changes. The reference level takes the new pin level only at that acceptance, and its reset value is 0.
- R3: A pin change that returns to the reference level before LOCAL_T ticks gives no wake. The filter count restarts from zero on the next change.
- R4: A remote request is accepted on the DOM_T-th tick of the second dominant phase. Before that, the first dominant phase (`bus_dom` = 1) must have lasted at least DOM_T ticks and the recessive phase at least REC_T ticks.
- R5: A dominant or recessive phase that ends before its minimum sends the pattern tracker back to idle, and no wake follows from it.
- R6: A remote pattern is accepted only if its last tick falls within TIMEOUT_T ticks, counting the first dominant tick as tick 1. If it does not, tracking restarts from idle.
- R7: Requests set the flags only while `low_power` = 1. While it is 0, the pattern tracker is held idle. The pin filter keeps running and absorbs pin changes into the reference level without waking.
- R8: `wake_src` is set by an accepted local request and never by a remote one. `leave_normal` clears it, and the clear wins over a set in the same cycle.
- R9: `enter_normal` or `uv_core` clears `wake_flag`, and the clear wins over a request accepted in the same cycle.
- R10: `wake_evt` is high for exactly one cycle, in the same cycle that an accepted request sets `wake_flag`.
- R11: No filter, phase or window count advances in a cycle with `tick` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-on state |
| tick | input | 1 | Time-base enable for all counts |
| wake_pin | input | 1 | Synchronised local wake pin level |
| bus_dom | input | 1 | Receiver reports bus dominant |
| low_power | input | 1 | Transceiver is in a low-power mode; arms detection |
| enter_normal | input | 1 | Pulse: normal mode entered, clears wake flag |
| leave_normal | input | 1 | Pulse: normal mode left, clears wake-source flag |
| uv_core | input | 1 | Core-supply undervoltage flag set, clears wake flag |
| wake_flag | output | 1 | Wake request seen |
| wake_src | output | 1 | Last wake came from the local pin |
| wake_evt | output | 1 | One-cycle pulse on an accepted request |

## Verification
The hardest case to reach from the ports is the edge of the remote window. A pattern whose last dominant tick lands on exactly the final tick of the window must still be accepted, and the same pattern with one more recessive tick must be dropped. The bench drives `bus_dom` cycle by cycle with `tick` held high, so phase lengths in cycles equal tick counts. It sends a 3/14/3 pattern, which ends on tick 20 of a 20-tick window, and then a 3/15/3 pattern, which runs one tick over. It also lines up a local acceptance with an undervoltage clear in the same cycle, which exercises the clear priority.

// File: rtl/wake_detector.sv
module wake_detector #(
  parameter int LOCAL_T   = 100,
  parameter int DOM_T     = 7,
  parameter int REC_T     = 7,
  parameter int TIMEOUT_T = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wake_pin,
  input  logic bus_dom,
  input  logic low_power,
  input  logic enter_normal,
  input  logic leave_normal,
  input  logic uv_core,
  output logic wake_flag,
  output logic wake_src,
  output logic wake_evt
);
  localparam int PMAXV = (DOM_T > REC_T) ? DOM_T : REC_T;
  localparam int LW = $clog2(LOCAL_T + 1);
  localparam int PW = $clog2(PMAXV + 1);
  localparam int TW = $clog2(TIMEOUT_T + 1);

  typedef enum logic [1:0] {S_IDLE, S_DOM1, S_REC, S_DOM2} st_t;

  logic          pin_ref;
  logic [LW-1:0] lcnt;
  st_t           state;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] wcnt;

  wire pin_diff  = wake_pin != pin_ref;
  wire local_hit = pin_diff && tick && (lcnt == LW'(LOCAL_T - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_ref <= 1'b0;
      lcnt    <= '0;
    end else if (!pin_diff) begin
      lcnt <= '0;
    end else if (local_hit) begin
      pin_ref <= wake_pin;
      lcnt    <= '0;
    end else if (tick) begin
      lcnt <= lcnt + 1'b1;
    end

  wire [PW-1:0] pinc = (tick && pcnt != PW'(PMAXV)) ? pcnt + 1'b1 : pcnt;
  wire dom_done   = pcnt >= PW'(DOM_T);
  wire rec_done   = pcnt >= PW'(REC_T);
  wire remote_hit = (state == S_DOM2) && bus_dom && tick && (pcnt >= PW'(DOM_T - 1));
  wire win_over   = (state != S_IDLE) && tick && (wcnt >= TW'(TIMEOUT_T - 1)) && !remote_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      pcnt  <= '0;
      wcnt  <= '0;
    end else if (!low_power || remote_hit || win_over) begin
      state <= S_IDLE;
      pcnt  <= '0;
      wcnt  <= '0;
    end else begin
      if (state != S_IDLE) wcnt <= wcnt + TW'(tick);
      case (state)
        S_IDLE:
          if (bus_dom) begin
            state <= S_DOM1;
            pcnt  <= PW'(tick);
            wcnt  <= TW'(tick);
          end
        S_DOM1:
          if (bus_dom) pcnt <= pinc;
          else if (dom_done) begin
            state <= S_REC;
            pcnt  <= PW'(tick);
          end else begin
            state <= S_IDLE;
            pcnt  <= '0;
            wcnt  <= '0;
          end
        S_REC:
          if (!bus_dom) pcnt <= pinc;
          else if (rec_done) begin
            state <= S_DOM2;
            pcnt  <= PW'(tick);
          end else begin
            state <= S_IDLE;
            pcnt  <= '0;
            wcnt  <= '0;
          end
        default:
          if (bus_dom) pcnt <= pinc;
          else begin
            state <= S_IDLE;
            pcnt  <= '0;
            wcnt  <= '0;
          end
      endcase
    end

  wire req = low_power && (local_hit || remote_hit);
  wire clr = enter_normal || uv_core;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_flag <= 1'b1;
      wake_src  <= 1'b1;
      wake_evt  <= 1'b0;
    end else begin
      wake_evt <= req && !clr;
      if (clr) wake_flag <= 1'b0;
      else if (req) wake_flag <= 1'b1;
      if (leave_normal) wake_src <= 1'b0;
      else if (low_power && local_hit && !clr) wake_src <= 1'b1;
    end
endmodule

module wake_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic low_power,
  input logic enter_normal,
  input logic leave_normal,
  input logic uv_core,
  input logic wake_flag,
  input logic wake_src,
  input logic wake_evt
);
  assert_evt_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> wake_flag);
  assert_flag_rise_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> wake_evt);
  assert_evt_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> $past(low_power));
  assert_evt_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> $past(tick));
  assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_normal || uv_core) |=> (!wake_flag && !wake_evt));
  assert_clear_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leave_normal |=> !wake_src);
  assert_src_rise_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_src) |-> wake_evt);
endmodule

bind wake_detector wake_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .low_power(low_power),
  .enter_normal(enter_normal), .leave_normal(leave_normal), .uv_core(uv_core),
  .wake_flag(wake_flag), .wake_src(wake_src), .wake_evt(wake_evt)
);

// File: tb/wake_detector_tb.sv
module wake_detector_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic wake_pin = 1'b0;
  logic bus_dom = 1'b0;
  logic low_power = 1'b0;
  logic enter_normal = 1'b0;
  logic leave_normal = 1'b0;
  logic uv_core = 1'b0;
  logic wake_flag, wake_src, wake_evt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wake_detector #(.LOCAL_T(4), .DOM_T(3), .REC_T(3), .TIMEOUT_T(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wake_pin(wake_pin), .bus_dom(bus_dom),
    .low_power(low_power), .enter_normal(enter_normal), .leave_normal(leave_normal),
    .uv_core(uv_core), .wake_flag(wake_flag), .wake_src(wake_src), .wake_evt(wake_evt)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic clear_all;
    low_power = 1'b0; enter_normal = 1'b1; leave_normal = 1'b1;
    cyc(1);
    enter_normal = 1'b0; leave_normal = 1'b0; low_power = 1'b1;
    cyc(1);
  endtask

  task automatic pattern(input int d1, input int r, input int d2);
    bus_dom = 1'b1; cyc(d1);
    bus_dom = 1'b0; cyc(r);
    bus_dom = 1'b1; cyc(d2);
    bus_dom = 1'b0;
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1", "flag in reset", wake_flag, 1'b1);
    chk("R1", "src in reset", wake_src, 1'b1);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "flag after reset", wake_flag, 1'b1);
    chk("R1", "src after reset", wake_src, 1'b1);
    chk("R1", "evt after reset", wake_evt, 1'b0);
    clear_all;
    chk("R9", "flag cleared by enter_normal", wake_flag, 1'b0);
    chk("R8", "src cleared by leave_normal", wake_src, 1'b0);
  endtask

  task automatic t_local_rise;
    wake_pin = 1'b1; cyc(3);
    chk("R2", "flag before filter end", wake_flag, 1'b0);
    cyc(1);
    chk("R2", "flag after rising filter", wake_flag, 1'b1);
    chk("R10", "evt on accept", wake_evt, 1'b1);
    chk("R8", "src on local wake", wake_src, 1'b1);
    cyc(1);
    chk("R10", "evt one cycle only", wake_evt, 1'b0);
  endtask

  task automatic t_local_fall;
    clear_all;
    wake_pin = 1'b0; cyc(4);
    chk("R2", "flag after falling filter", wake_flag, 1'b1);
  endtask

  task automatic t_glitch;
    clear_all;
    wake_pin = 1'b1; cyc(3);
    wake_pin = 1'b0; cyc(10);
    chk("R3", "short pulse no wake", wake_flag, 1'b0);
    wake_pin = 1'b1; cyc(3);
    chk("R3", "count restarted", wake_flag, 1'b0);
    cyc(1);
    chk("R3", "full change accepted", wake_flag, 1'b1);
  endtask

  task automatic t_tick;
    clear_all;
    tick = 1'b0; wake_pin = 1'b0; cyc(20);
    chk("R11", "no progress without tick", wake_flag, 1'b0);
    tick = 1'b1; cyc(4);
    chk("R11", "wake after ticks", wake_flag, 1'b1);
  endtask

  task automatic t_remote;
    clear_all;
    pattern(3, 3, 2);
    chk("R5", "dom2 one tick short", wake_flag, 1'b0);
    clear_all;
    bus_dom = 1'b1; cyc(3);
    bus_dom = 1'b0; cyc(3);
    bus_dom = 1'b1; cyc(2);
    chk("R4", "before dom2 complete", wake_flag, 1'b0);
    cyc(1);
    chk("R4", "remote wake", wake_flag, 1'b1);
    chk("R10", "evt on remote", wake_evt, 1'b1);
    chk("R8", "src stays low on remote", wake_src, 1'b0);
    bus_dom = 1'b0; cyc(2);
  endtask

  task automatic t_short_phases;
    clear_all;
    pattern(2, 3, 3); cyc(3);
    chk("R5", "short dom1 no wake", wake_flag, 1'b0);
    clear_all;
    pattern(3, 2, 3); cyc(3);
    chk("R5", "short rec no wake", wake_flag, 1'b0);
  endtask

  task automatic t_window;
    clear_all;
    pattern(3, 14, 3);
    chk("R6", "pattern on last window tick", wake_flag, 1'b1);
    cyc(2);
    clear_all;
    pattern(3, 15, 3); cyc(3);
    chk("R6", "pattern one tick late", wake_flag, 1'b0);
  endtask

  task automatic t_disarmed;
    clear_all;
    low_power = 1'b0;
    wake_pin = ~wake_pin; cyc(10);
    pattern(3, 3, 3); cyc(2);
    chk("R7", "no wake when disarmed", wake_flag, 1'b0);
    low_power = 1'b1; cyc(10);
    chk("R7", "pin change absorbed", wake_flag, 1'b0);
  endtask

  task automatic t_clear_priority;
    clear_all;
    wake_pin = ~wake_pin; cyc(3);
    uv_core = 1'b1; cyc(1);
    uv_core = 1'b0;
    chk("R9", "uv clear beats request", wake_flag, 1'b0);
    chk("R9", "no evt when cleared", wake_evt, 1'b0);
    wake_pin = ~wake_pin; cyc(4);
    chk("R9", "flag set again", wake_flag, 1'b1);
    enter_normal = 1'b1; cyc(1);
    enter_normal = 1'b0;
    chk("R9", "enter_normal clears", wake_flag, 1'b0);
  endtask

  initial begin
    t_reset;
    t_local_rise;
    t_local_fall;
    t_glitch;
    t_tick;
    t_remote;
    t_short_phases;
    t_window;
    t_disarmed;
    t_clear_priority;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule